// File: doc/BRIEF.md
# ADC Sample Voltage Display Formatter

The block sits behind a 12-bit parallel pipelined ADC that needs no setup and only a running sample clock. On every clock edge it registers the sample bus with its bit order reversed, because the converter presents its most significant bit on bus line 0. It registers the over-range flag in the same edge.

The captured code is in straight binary, centred on mid-scale. The block turns it into a signed differential voltage in millivolts, with a 2 V full scale. A sequential shift-and-add-3 engine splits the magnitude into four decimal digits. The engine restarts as soon as it finishes, and each finished result is latched for the display.

A scanner drives a six-position multiplexed seven-segment display from left to right. The first position flags over-range. The second shows the sign. The last four show the magnitude as X.XXX volts.

Top module: `adc_volt_display`

## Requirements
- R1: The capture register stores the bus reversed on every clock edge: bus line 0 carries the code's bit 11 (MSB) and line 11 carries bit 0 (LSB).
- R2: The signed value is code minus 2048. When it is negative, position 1 shows a minus glyph (segment g only). When it is zero or positive, position 1 is blank.
- R3: The displayed magnitude in millivolts is |code − 2048| × 2000 / 2048, rounded half up. It therefore lies in 0..2000, for example code 0 gives 2000, code 4095 gives 1999 and code 2047 gives 1.
- R4: Positions 2, 3, 4 and 5 show the thousands, hundreds, tens and units digits of the millivolt value. The decimal point is lit at position 2 only.
- R5: Position 0 lights all seven segments when the over-range input was high for the sample behind the shown result, and is blank otherwise.
- R6: The digit select is active low with at most one line low. The active position advances 0→1→…→5→0, dwelling 2^SCAN_W clocks on each position.
- R7: `seg_out[6:0]` carry segments a..g (bit 0 = a) inverted, so a lit segment drives 0. `seg_out[7]` is the decimal point, high when lit. The digit glyphs are the usual ones (0 = a b c d e f, 1 = b c, …).
- R8: While reset is low, all select lines are high and `seg_out` is 8'h7F. After release the latched result is cleared: position 0 is blank first, and position 2 shows "0." until the first conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_bus | input | 12 | Parallel sample bus, bit order reversed |
| adc_ovr | input | 1 | Over-range flag from the converter |
| digit_sel_n | output | 6 | Digit select, one-hot active low, bit 0 = leftmost |
| seg_out | output | 8 | Inverted segments a..g in [6:0], decimal point in [7] |

## Verification
A wrong bit in the capture register or in the rounding product shows up as a wrong digit glyph at positions 2 to 5. This appears about 2×(MAG_W+1) clocks after the input changes, once the next conversion has been latched. A corrupted sign or over-range latch appears at positions 1 or 0 in the same frame. A fault in the scan counter shows within one dwell period, as a select line out of order or a dwell of the wrong length. The bench drives the mid-scale codes either side of zero, both ends of the range, an over-range sample and random codes. It then reads every position of a full frame against glyphs computed independently.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int ADC_W  = 12;
  localparam int MAG_W  = 14;
  localparam int NDIG   = 4;
  localparam int NPOS   = NDIG + 2;
  localparam int FS_MV  = 2000;
  localparam int PROD_W = ADC_W + 12;
  localparam int WORK_W = 4 * NDIG + MAG_W;

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  localparam seg_t SEG_BLANK = 7'h00;
  localparam seg_t SEG_MINUS = 7'h40;
  localparam seg_t SEG_FULL  = 7'h7F;

  // Mid-scale code: zero differential input
  function automatic logic [ADC_W-1:0] mid_code();
    return {1'b1, {(ADC_W-1){1'b0}}};
  endfunction

  function automatic logic code_is_negative(input logic [ADC_W-1:0] c);
    return (c < mid_code());
  endfunction

  // |code - mid| scaled to millivolts, rounded half up, via multiply and shift
  function automatic logic [MAG_W-1:0] code_to_mv(input logic [ADC_W-1:0] c);
    logic [ADC_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    mag  = (c >= mid_code()) ? (c - mid_code()) : (mid_code() - c);
    prod = PROD_W'(mag) * PROD_W'(FS_MV) + (PROD_W'(1) << (ADC_W-2));
    return MAG_W'(prod >> (ADC_W-1));
  endfunction

  // One double-dabble iteration: correct each decimal nibble, then shift
  function automatic logic [WORK_W-1:0] dd_step(input logic [WORK_W-1:0] w);
    logic [WORK_W-1:0] t;
    t = w;
    for (int i = 0; i < NDIG; i++) begin
      if (t[MAG_W+4*i +: 4] >= 4'd5)
        t[MAG_W+4*i +: 4] = t[MAG_W+4*i +: 4] + 4'd3;
    end
    return t << 1;
  endfunction

  // Active-high glyph, bit 0 = segment a
  function automatic seg_t digit_glyph(input bcd_t d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return SEG_BLANK;
    endcase
  endfunction
endpackage

// File: rtl/avd_capture.sv
module avd_capture
  import avd_pkg::*;
#(
  parameter int W = ADC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         ovr_in,
  output logic [W-1:0] code_q,
  output logic         ovr_q
);
  logic [W-1:0] swapped;

  generate
    for (genvar b = 0; b < W; b++) begin : g_swap
      assign swapped[b] = bus_in[W-1-b];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      code_q <= swapped;
      ovr_q  <= ovr_in;
    end
  end

  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  AST_MSB_FROM_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (code_q[W-1] == $past(bus_in[0])));  // R1
  AST_LSB_FROM_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (code_q[0] == $past(bus_in[W-1])));  // R1
endmodule

// File: rtl/avd_bcd_engine.sv
module avd_bcd_engine
  import avd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADC_W-1:0]      code,
  input  logic                  ovr,
  output bcd_t [NDIG-1:0]       digits,
  output logic                  neg_q,
  output logic                  ovr_q,
  output logic                  conv_done
);
  localparam int CNT_W = $clog2(MAG_W + 1);

  logic [CNT_W-1:0]  step_cnt;
  logic [WORK_W-1:0] work, work_nxt;
  logic              neg_w, ovr_w;
  logic [MAG_W-1:0]  mv_in;

  assign mv_in     = code_to_mv(code);
  assign work_nxt  = dd_step(work);
  assign conv_done = (step_cnt == CNT_W'(MAG_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      work     <= '0;
      neg_w    <= 1'b0;
      ovr_w    <= 1'b0;
      digits   <= '0;
      neg_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (step_cnt == '0) begin
      work     <= {{(4*NDIG){1'b0}}, mv_in};
      neg_w    <= code_is_negative(code);
      ovr_w    <= ovr;
      step_cnt <= CNT_W'(1);
    end else begin
      work <= work_nxt;
      if (conv_done) begin
        for (int i = 0; i < NDIG; i++)
          digits[i] <= work_nxt[MAG_W+4*i +: 4];
        neg_q    <= neg_w;
        ovr_q    <= ovr_w;
        step_cnt <= '0;
      end else begin
        step_cnt <= step_cnt + CNT_W'(1);
      end
    end
  end

  AST_MV_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    mv_in <= MAG_W'(FS_MV));  // R3
  AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (digits[0] <= 4'd9) && (digits[1] <= 4'd9) && (digits[2] <= 4'd9) && (digits[3] <= 4'd9));  // R4
  AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    neg_q |-> (digits != '0));  // R2
endmodule

// File: rtl/avd_scan.sv
module avd_scan
  import avd_pkg::*;
#(
  parameter int SCAN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bcd_t [NDIG-1:0] digits,
  input  logic            neg,
  input  logic            ovr,
  output logic [NPOS-1:0] sel_n,
  output logic [7:0]      seg
);
  localparam int IDX_W = $clog2(NPOS);

  logic [SCAN_W-1:0] presc;
  logic [IDX_W-1:0]  pos_idx;
  logic              step_tick;
  seg_t              glyph;
  logic              dp;

  assign step_tick = &presc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      pos_idx <= '0;
    end else begin
      presc <= presc + SCAN_W'(1);
      if (step_tick)
        pos_idx <= (pos_idx == IDX_W'(NPOS-1)) ? '0 : pos_idx + IDX_W'(1);
    end
  end

  always_comb begin
    dp = 1'b0;
    case (pos_idx)
      IDX_W'(0): glyph = ovr ? SEG_FULL : SEG_BLANK;
      IDX_W'(1): glyph = neg ? SEG_MINUS : SEG_BLANK;
      IDX_W'(2): begin glyph = digit_glyph(digits[3]); dp = 1'b1; end
      IDX_W'(3): glyph = digit_glyph(digits[2]);
      IDX_W'(4): glyph = digit_glyph(digits[1]);
      IDX_W'(5): glyph = digit_glyph(digits[0]);
      default:   glyph = SEG_BLANK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n <= '1;
      seg   <= {1'b0, ~SEG_BLANK};
    end else begin
      sel_n <= ~(NPOS'(1) << pos_idx);
      seg   <= {dp, ~glyph};
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));  // R6
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(pos_idx));  // R6
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && pos_idx == IDX_W'(NPOS-1)) |=> (pos_idx == '0));  // R6
  AST_DP_PLACEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    seg[7] |-> !sel_n[2]);  // R4
  AST_SIGN_GLYPH: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n[1] |-> (seg[6:0] == ~SEG_MINUS || seg[6:0] == ~SEG_BLANK));  // R2
endmodule

// File: rtl/adc_volt_display.sv
module adc_volt_display
  import avd_pkg::*;
#(
  parameter int SCAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] adc_bus,
  input  logic             adc_ovr,
  output logic [NPOS-1:0]  digit_sel_n,
  output logic [7:0]       seg_out
);
  logic [ADC_W-1:0] code_q;
  logic             cap_ovr;
  bcd_t [NDIG-1:0]  digits;
  logic             neg_q, ovr_q, conv_done;

  avd_capture #(.W(ADC_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_in (adc_bus),
    .ovr_in (adc_ovr),
    .code_q (code_q),
    .ovr_q  (cap_ovr)
  );

  avd_bcd_engine u_bcd (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code_q),
    .ovr       (cap_ovr),
    .digits    (digits),
    .neg_q     (neg_q),
    .ovr_q     (ovr_q),
    .conv_done (conv_done)
  );

  avd_scan #(.SCAN_W(SCAN_W)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .digits (digits),
    .neg    (neg_q),
    .ovr    (ovr_q),
    .sel_n  (digit_sel_n),
    .seg    (seg_out)
  );

  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(digits));  // R4
endmodule

// File: tb/adc_volt_display_tb.sv
module adc_volt_display_tb;
  localparam int SCAN_W = 2;
  localparam int DWELL  = 1 << SCAN_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] adc_bus = '0;
  logic        adc_ovr = 1'b0;
  logic [5:0]  digit_sel_n;
  logic [7:0]  seg_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] pos [6]; int code; } frame_t;
  frame_t sb_q [$];

  always #2 clk = ~clk;

  adc_volt_display #(.SCAN_W(SCAN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .adc_bus(adc_bus), .adc_ovr(adc_ovr),
    .digit_sel_n(digit_sel_n), .seg_out(seg_out)
  );

  function automatic logic [6:0] glyph_of(int d);
    logic [6:0] tbl [10] = '{7'b0111111, 7'b0000110, 7'b1011011, 7'b1001111, 7'b1100110,
                             7'b1101101, 7'b1111101, 7'b0000111, 7'b1111111, 7'b1101111};
    return tbl[d];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver: present a code (bus reversed per R1), wait for conversion, push expectation
  task automatic drive(input int code, input bit ovr);
    frame_t f;
    int signed_v, mag, mv;
    logic [11:0] c;
    c = 12'(code);
    @(negedge clk);
    adc_bus = {<<{c}};
    adc_ovr = ovr;
    repeat (50) @(negedge clk);
    signed_v = code - 2048;
    mag = (signed_v < 0) ? -signed_v : signed_v;
    mv = (mag * 1000 + 512) / 1024;                       // R3
    f.code = code;
    f.pos[0] = {1'b0, ovr ? 7'h00 : 7'h7F};              // R5
    f.pos[1] = {1'b0, (signed_v < 0) ? ~7'b1000000 : 7'h7F}; // R2
    f.pos[2] = {1'b1, ~glyph_of(mv / 1000)};              // R4 R7
    f.pos[3] = {1'b0, ~glyph_of((mv / 100) % 10)};
    f.pos[4] = {1'b0, ~glyph_of((mv / 10) % 10)};
    f.pos[5] = {1'b0, ~glyph_of(mv % 10)};
    sb_q.push_back(f);
    wait (sb_q.size() == 0);
  endtask

  // Monitor: capture one full scan frame and compare each position
  initial begin
    forever begin
      frame_t f;
      bit [5:0] seen;
      wait (sb_q.size() > 0);
      f = sb_q[0];
      seen = '0;
      while (seen != 6'h3F) begin
        @(negedge clk);
        for (int p = 0; p < 6; p++) begin
          if (digit_sel_n == ~(6'(1) << p) && !seen[p]) begin
            seen[p] = 1'b1;
            case (p)
              0: check(seg_out == f.pos[p], "R5 overrange digit", 32'(seg_out), 32'(f.pos[p]));
              1: check(seg_out == f.pos[p], "R2 sign digit", 32'(seg_out), 32'(f.pos[p]));
              2: check(seg_out == f.pos[p], "R4 R7 volts digit with point", 32'(seg_out), 32'(f.pos[p]));
              default: check(seg_out == f.pos[p], "R1 R3 magnitude digit", 32'(seg_out), 32'(f.pos[p]));
            endcase
          end
        end
      end
      void'(sb_q.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [5:0] last_sel;
    int dwell;
    int first_idx;
    adc_bus = {<<{12'h800}};
    repeat (4) @(negedge clk);
    // R8 reset state
    check(digit_sel_n == 6'h3F, "R8 select during reset", 32'(digit_sel_n), 32'h3F);
    check(seg_out == 8'h7F, "R8 segments during reset", 32'(seg_out), 32'h7F);
    rst_n = 1'b1;
    @(negedge clk);
    check(digit_sel_n == 6'b111110, "R8 first position after reset", 32'(digit_sel_n), 32'h3E);
    check(seg_out == 8'h7F, "R8 overrange digit cleared", 32'(seg_out), 32'h7F);
    wait (digit_sel_n == 6'b111011);
    @(negedge clk);
    check(seg_out == 8'hC0, "R8 cleared result shows 0.", 32'(seg_out), 32'hC0);
    // R6 scan order and dwell
    last_sel = digit_sel_n;
    dwell = 0;
    first_idx = 1;
    for (int n = 0; n < 12; n++) begin
      int cur, prv;
      dwell = 0;
      while (digit_sel_n == last_sel) begin
        @(negedge clk);
        dwell++;
      end
      cur = -1;
      prv = -1;
      for (int p = 0; p < 6; p++) begin
        if (digit_sel_n == ~(6'(1) << p)) cur = p;
        if (last_sel == ~(6'(1) << p)) prv = p;
      end
      check(cur == (prv + 1) % 6, "R6 scan order", 32'(cur), 32'((prv + 1) % 6));
      if (!first_idx)
        check(dwell == DWELL, "R6 dwell length", 32'(dwell), 32'(DWELL));
      first_idx = 0;
      last_sel = digit_sel_n;
    end
    // Main function
    drive(0, 1'b0);
    drive(2047, 1'b0);
    drive(2048, 1'b0);
    drive(4095, 1'b0);
    drive(1234, 1'b1);
    drive(2049, 1'b0);
    drive(3000, 1'b1);
    for (int k = 0; k < 6; k++)
      drive(int'($urandom_range(0, 4095)), 1'b0);
    finish_run();
  end
endmodule